// File: doc/BRIEF.md
# Packed Compare, Min/Max and Absolute-Difference Sum Unit

This block takes two 64-bit operands that are split into equal lanes, applies one of four lane-wise operations, and registers the result. The operations are a compare that yields a mask, a minimum, a maximum, and a sum of absolute differences. The compare fills each lane with ones when the chosen relation holds and with zeros when it does not. The relation is either equality or signed greater-than. The compare runs on 1-, 2- or 4-byte lanes.

For minimum and maximum, the lane size also sets the signedness. Byte lanes are read as unsigned numbers and 2-byte lanes as signed numbers. The absolute-difference sum reduces all eight byte lanes to one scalar, which is placed in the low bits of the result. The result appears one cycle after a valid input, together with a valid flag. It keeps its value until the next valid input arrives.

Top module: `simd_cmp_minmax_sad`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `result` is all zeros.
- R2: Each cycle, `out_valid` takes the value that `in_valid` had in the cycle before, and `result` is loaded only on a cycle with `in_valid` high.
- R3: While `in_valid` is low, `result` keeps its value whatever the operands and selects are.
- R4: Opcode encoding is 00 compare, 01 minimum, 10 maximum, 11 absolute-difference sum. For compare, `lane_sz` 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 selects 32-bit lanes. Each lane of `result` is all ones when the relation holds and all zeros when it does not.
- R5: `rel_gt` = 0 tests `op_a` lane equal to `op_b` lane. `rel_gt` = 1 tests `op_a` lane greater than `op_b` lane, with both read as two's-complement signed values.
- R6: Minimum and maximum with `lane_sz` = 0 work on eight unsigned 8-bit lanes, and `rel_gt` has no effect.
- R7: Minimum and maximum with any nonzero `lane_sz` work on four signed 16-bit lanes, and `rel_gt` has no effect.
- R8: The absolute-difference sum adds |a−b| over all eight unsigned byte lanes. The total goes in `result[10:0]` and bits 63:11 are zero. `lane_sz` and `rel_gt` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| opcode | input | 2 | Operation select |
| lane_sz | input | 2 | Lane width select |
| rel_gt | input | 1 | Relation for compare: 0 equal, 1 signed greater |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered lane-wise result |

## Verification
Equality hits on wide lanes are the hardest case to produce. With sweeping operands, two 16- or 32-bit lanes almost never match, so the stimulus builds `op_b` as a copy of `op_a` with exactly one byte flipped. That leaves most lanes equal and one lane different. The sweep covers every first-byte value against a stride of second-byte values, with a different offset per lane so that sign boundaries fall in different lanes. The unused selects are varied inside each configuration to show that they have no effect.

// File: rtl/simd_cmp_minmax_sad.sv
`timescale 1ns/1ps
module simd_cmp_minmax_sad #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        opcode,
  input  logic [1:0]        lane_sz,
  input  logic              rel_gt,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int N8    = DATA_W / 8;
  localparam int N16   = DATA_W / 16;
  localparam int N32   = DATA_W / 32;
  localparam int SAD_W = $clog2(N8 * 255 + 1);
  localparam logic [1:0] OP_CMP = 2'd0;
  localparam logic [1:0] OP_MIN = 2'd1;
  localparam logic [1:0] OP_MAX = 2'd2;

  logic [DATA_W-1:0] cmp8, cmp16, cmp32, mm8, mm16, nxt;
  logic [7:0]        adiff [N8];
  logic [SAD_W-1:0]  sad;
  wire               want_max = (opcode == OP_MAX);

  for (genvar g = 0; g < N8; g++) begin : g_b
    wire [7:0] a = op_a[8*g +: 8];
    wire [7:0] b = op_b[8*g +: 8];
    wire hit = rel_gt ? ($signed(a) > $signed(b)) : (a == b);
    wire big = a > b;
    assign cmp8[8*g +: 8] = {8{hit}};
    assign mm8[8*g +: 8]  = (want_max == big) ? a : b;
    assign adiff[g]       = big ? a - b : b - a;
  end

  for (genvar g = 0; g < N16; g++) begin : g_h
    wire [15:0] a = op_a[16*g +: 16];
    wire [15:0] b = op_b[16*g +: 16];
    wire hit = rel_gt ? ($signed(a) > $signed(b)) : (a == b);
    wire big = $signed(a) > $signed(b);
    assign cmp16[16*g +: 16] = {16{hit}};
    assign mm16[16*g +: 16]  = (want_max == big) ? a : b;
  end

  for (genvar g = 0; g < N32; g++) begin : g_w
    wire [31:0] a = op_a[32*g +: 32];
    wire [31:0] b = op_b[32*g +: 32];
    wire hit = rel_gt ? ($signed(a) > $signed(b)) : (a == b);
    assign cmp32[32*g +: 32] = {32{hit}};
  end

  always_comb begin
    sad = '0;
    for (int i = 0; i < N8; i++) sad = sad + SAD_W'(adiff[i]);
  end

  always_comb begin
    case (opcode)
      OP_CMP:  nxt = (lane_sz == 2'd0) ? cmp8 : (lane_sz == 2'd1) ? cmp16 : cmp32;
      OP_MIN,
      OP_MAX:  nxt = (lane_sz == 2'd0) ? mm8 : mm16;
      default: nxt = DATA_W'(sad);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/simd_cmp_minmax_sad_chk.sv
module simd_cmp_minmax_sad_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        opcode,
  input logic [1:0]        lane_sz,
  input logic              rel_gt,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int SAD_W = $clog2((DATA_W / 8) * 255 + 1);

  logic bytes_ok;
  always_comb begin
    bytes_ok = 1'b1;
    for (int i = 0; i < DATA_W / 8; i++)
      if (result[8*i +: 8] != 8'h00 && result[8*i +: 8] != 8'hFF) bytes_ok = 1'b0;
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_byte_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'd0 && lane_sz == 2'd0) |=> bytes_ok);
  p_equal_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'd0 && !rel_gt && op_a == op_b) |=> (&result));
  p_sad_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'd3) |=> (result[DATA_W-1:SAD_W] == '0));
endmodule

bind simd_cmp_minmax_sad simd_cmp_minmax_sad_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .opcode(opcode), .lane_sz(lane_sz), .rel_gt(rel_gt),
  .out_valid(out_valid), .result(result)
);

// File: tb/simd_cmp_minmax_sad_tb.sv
`timescale 1ns/1ps
module simd_cmp_minmax_sad_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  opcode = '0, lane_sz = '0;
  logic        rel_gt = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simd_cmp_minmax_sad u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .lane_sz(lane_sz), .rel_gt(rel_gt),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint lane_u(input logic [63:0] v, input int k, input int w);
    return longint'((v >> (k * w)) & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic longint lane_s(input logic [63:0] v, input int k, input int w);
    longint u = lane_u(v, k, w);
    return (u >= (longint'(1) << (w - 1))) ? u - (longint'(1) << w) : u;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] op, input logic [1:0] ls,
                                        input logic g);
    logic [63:0] r = '0;
    int w;
    longint s = 0;
    case (op)
      2'd0: begin
        w = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
        for (int k = 0; k < 64 / w; k++) begin
          bit hit = g ? (lane_s(a, k, w) > lane_s(b, k, w)) : (lane_u(a, k, w) == lane_u(b, k, w));
          if (hit) r |= ((64'd1 << w) - 64'd1) << (k * w);
        end
      end
      2'd1, 2'd2: begin
        w = (ls == 0) ? 8 : 16;
        for (int k = 0; k < 64 / w; k++) begin
          longint x = (w == 8) ? lane_u(a, k, w) : lane_s(a, k, w);
          longint y = (w == 8) ? lane_u(b, k, w) : lane_s(b, k, w);
          longint m = (op == 2'd1) ? ((x < y) ? x : y) : ((x > y) ? x : y);
          r |= (64'(m) & ((64'd1 << w) - 64'd1)) << (k * w);
        end
      end
      default: begin
        for (int k = 0; k < 8; k++) begin
          longint d = lane_u(a, k, 8) - lane_u(b, k, 8);
          s += (d < 0) ? -d : d;
        end
        r = 64'(s);
      end
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                       input logic [1:0] ls, input logic g, input string tag);
    logic [63:0] e = model(a, b, op, ls, g);
    op_a = a; op_b = b; opcode = op; lane_sz = ls; rel_gt = g; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_valid === 1'b1, "R2", {63'd0, out_valid}, 64'd1);
    chk(result === e, tag, result, e);
  endtask

  task automatic idle_hold();
    logic [63:0] keep = result;
    in_valid = 1'b0; op_a = ~op_a; op_b = op_b + 64'h0101; opcode = opcode + 2'd1;
    @(posedge clk); @(negedge clk);
    chk(out_valid === 1'b0, "R2", {63'd0, out_valid}, 64'd0);
    chk(result === keep, "R3", result, keep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
    chk(result === 64'd0, "R1", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 2'd0, 2'd0, 1'b1, "R5");
    apply(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 2'd1, 2'd0, 1'b0, "R6");
    apply(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 2'd1, 2'd1, 1'b1, "R7");
    apply(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 2'd2, 2'd3, 1'b0, "R7");
    apply(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd2, 1'b1, "R8");
    idle_hold();
    apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'd0, 2'd2, 1'b0, "R4");
    apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'd3, 2'd1, 1'b0, "R8");

    for (int x = 0; x < 256; x++) begin
      for (int yi = 0; yi < 52; yi++) begin
        int y = yi * 5;
        logic [63:0] a, b;
        for (int i = 0; i < 8; i++) begin
          a[8*i +: 8] = 8'(x + i * 37);
          b[8*i +: 8] = 8'(y + i * 53);
        end
        if (yi % 4 == 0) b = a ^ (64'h0000_0000_0000_00FF << (8 * (x % 8)));
        apply(a, b, 2'd0, 2'd0, 1'b0, "R4");
        apply(a, b, 2'd0, 2'd0, 1'b1, "R5");
        apply(a, b, 2'd0, 2'd1, 1'b0, "R4");
        apply(a, b, 2'd0, 2'd1, 1'b1, "R5");
        apply(a, b, 2'd0, 2'(2 + (x & 1)), 1'(y & 1), "R4");
        apply(a, b, 2'(1 + (x & 1)), 2'd0, 1'(y & 1), "R6");
        apply(a, b, 2'(1 + (y & 1)), 2'(1 + (x % 3)), 1'(x & 1), "R7");
        apply(a, b, 2'd3, 2'(x % 4), 1'(y & 1), "R8");
        if (yi == 0) idle_hold();
      end
    end

    in_valid = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule